// File: doc/BRIEF.md
# SPI Slave Front End with Per-Transaction Clock Mode Detection

This block is the serial edge of an SPI slave memory device. It sits between the four serial pins and an internal command decoder. A system clock oversamples the serial clock, chip select and serial input. The block finds the serial clock edges and turns the incoming bit stream into bytes. It also shifts a response byte out, most significant bit first.

The block does not need to be told the bus mode. Each time chip select goes low, it records the level at which the serial clock is idling. A high idle level means mode 3 and a low idle level means mode 0. In both modes, input bits are sampled on rising serial clock edges and output bits change on falling edges. The first falling edge of a mode 3 transaction comes before any bit has been sampled, so that edge does not move the output.

After each eighth sampled bit, the decoder side gets a one-cycle byte strobe. The block also asks the decoder for the next transmit byte, using a one-cycle take strobe. When chip select goes high, the transaction ends: any partial byte is dropped and the data output is released. The serial clock must hold each level for at least three system clock cycles.

Top module: `spi_mode_frontend`

## Requirements
- R1: While reset is held and in the cycle after it, the latched mode is mode 3 (`mode3` = 1), `so_oe` is 0 and no byte strobe is issued.
- R2: A synchronized chip select falling edge latches the serial clock level seen in that cycle: high gives `mode3` = 1 and low gives `mode3` = 0. At all other times the mode holds its value.
- R3: `so_oe` is 1 only inside a transaction, which begins at a chip select falling edge. One cycle after chip select is seen high, `so_oe` is 0.
- R4: If chip select is already low when reset ends, no transaction starts. Serial clock activity then gives no strobe and `so_oe` stays 0 until chip select has gone high and then low again.
- R5: While reset is active, serial bits are ignored and no byte is assembled or strobed, even if they arrive inside a transaction.
- R6: Input bits are sampled on rising serial clock edges, MSB first. After every eighth bit, `rx_valid` pulses for exactly one cycle with the byte on `rx_data`. Back-to-back bytes in one transaction are each strobed.
- R7: If chip select goes high in the middle of a byte, the partial byte is discarded without a strobe. The next transaction starts its bit count at zero.
- R8: `so` presents bit 7 of the loaded byte from the start of the transaction, so the first bit is already valid in mode 0 as chip select falls. Each falling edge that follows a sampled bit moves `so` to the next lower bit. The leading falling edge of a mode 3 transaction leaves `so` unchanged.
- R9: `tx_take` pulses for one cycle on each chip select falling edge. It also pulses on the first falling serial clock edge after each completed byte. `tx_data` is captured in that same cycle and becomes the next output byte.
- R10: A rising serial clock edge whose synchronized copy arrives in the same cycle as chip select going high is ignored, even if it would be the eighth bit: no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid when `so_oe` is 1 |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| mode3 | output | 1 | Latched bus mode: 1 = mode 3, 0 = mode 0 |
| rx_data | output | DATA_W | Last assembled receive byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| tx_data | input | DATA_W | Next response byte from the decoder |
| tx_take | output | 1 | One-cycle strobe: `tx_data` was captured |

## Verification
Two things can happen in the same synchronized cycle: the eighth rising serial clock edge of a byte, which would complete the byte, and chip select rising, which would abort it. The bench provokes this by changing both pins on the same system clock edge, so that they pass through the synchronizer together. The correct outcome is no byte strobe, a released output, and a clean, correctly aligned byte in the next transaction. Constrained random transactions, with random mode, byte count and data, surround this corner case along with directed reset and abort cases.

// File: rtl/spi_mfe_pkg.sv
// Package: shared types for the SPI mode-detecting front end.
// Assumes: one system clock domain; serial pins are oversampled.
package spi_mfe_pkg;

    // Bus mode encoding: the value equals the idle serial clock level.
    typedef enum logic {
        MODE_0 = 1'b0,
        MODE_3 = 1'b1
    } spi_mode_e;

    // Edge events decoded from the synchronized pins, one cycle each.
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
    } spi_evt_t;

    // Reset value for the synchronizer vector {cs_n, sck, si}:
    // chip select treated as asserted so a held-low select never looks like a fall.
    localparam logic [2:0] PIN_RST_VAL = 3'b010;

endpackage

// File: rtl/spi_mfe_sync.sv
// Module: spi_mfe_sync
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: each bit may be sampled independently; the reset value is
// chosen per bit by the parent so that reset never fabricates an edge.
module spi_mfe_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] pipe [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage: capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= RST_VAL;
                else        pipe[i] <= d_in;
            end
        end else begin : g_next
            // Later stages: pass the value one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= RST_VAL;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q_out = pipe[STAGES-1];

endmodule

// File: rtl/spi_mfe_ctrl.sv
// Module: spi_mfe_ctrl
// Decodes pin edges, tracks whether a transaction is active and latches
// the bus mode from the idle clock level at each chip select fall.
// Assumes: inputs are already synchronized; serial clock edges count only
// while active and while chip select is low in the same cycle.
module spi_mfe_ctrl
    import spi_mfe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_cs,
    input  logic      s_sck,
    output spi_evt_t  evt,
    output logic      active,
    output spi_mode_e mode
);

    logic p_cs;
    logic p_sck;

    // Hold previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_cs  <= PIN_RST_VAL[2];
            p_sck <= PIN_RST_VAL[1];
        end else begin
            p_cs  <= s_cs;
            p_sck <= s_sck;
        end
    end

    // Edge decode; clock edges qualified by an open transaction.
    always_comb begin
        evt.cs_fall  = p_cs & ~s_cs;
        evt.cs_rise  = s_cs & ~p_cs;
        evt.sck_rise = s_sck & ~p_sck & ~s_cs & active;
        evt.sck_fall = ~s_sck & p_sck & ~s_cs & active;
    end

    // Transaction state: opened by a select fall, closed by select high.
    always_ff @(posedge clk) begin
        if (!rst_n)            active <= 1'b0;
        else if (s_cs)         active <= 1'b0;
        else if (evt.cs_fall)  active <= 1'b1;
    end

    // Mode latch: idle clock level at the select fall picks the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)            mode <= MODE_3;
        else if (evt.cs_fall)  mode <= spi_mode_e'(s_sck);
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mode == MODE_3 && !active));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.cs_fall |=> $stable(mode));

    p_idle_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs |=> !active);

    p_edge_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.sck_rise && evt.sck_fall));

endmodule

// File: rtl/spi_mfe_rx.sv
// Module: spi_mfe_rx
// Receive shifter: samples serial input on qualified rising edges, MSB
// first, and strobes each completed byte for one cycle.
// Assumes: clr is high whenever chip select is high; rising edges are
// already qualified by the controller.
module spi_mfe_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sck_rise,
    input  logic              si,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int              CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;

    // Shift, count and strobe; a select-high clear drops any partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clr) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[DATA_W-2:0], si};
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    rx_data  <= {shreg[DATA_W-2:0], si};
                    rx_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    p_reset_no_strobe_r5: assert property (@(posedge clk)
        !rst_n |=> !rx_valid);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_no_strobe_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rx_valid);

endmodule

// File: rtl/spi_mfe_tx.sv
// Module: spi_mfe_tx
// Transmit shifter: loads a byte at select fall and after each completed
// byte, and advances the output bit on falling edges that follow a sample.
// Assumes: byte_done arrives before the next falling edge (clock phase of
// at least three system cycles).
module spi_mfe_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] tx_data,
    output logic              so,
    output logic              tx_take
);

    logic [DATA_W-1:0] shreg;
    logic              armed;
    logic              pending;

    // Load, reload and shift control for the output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            armed   <= 1'b0;
            pending <= 1'b0;
            tx_take <= 1'b0;
        end else begin
            tx_take <= 1'b0;
            if (clr) begin
                armed   <= 1'b0;
                pending <= 1'b0;
            end else if (cs_fall) begin
                shreg   <= tx_data;
                tx_take <= 1'b1;
                armed   <= 1'b0;
                pending <= 1'b0;
            end else begin
                if (byte_done) pending <= 1'b1;
                if (sck_rise)  armed   <= 1'b1;
                if (sck_fall) begin
                    if (pending) begin
                        shreg   <= tx_data;
                        tx_take <= 1'b1;
                        pending <= 1'b0;
                        armed   <= 1'b0;
                    end else if (armed) begin
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                        armed <= 1'b0;
                    end
                end
            end
        end
    end

    assign so = shreg[DATA_W-1];

    p_so_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_fall && !sck_fall) |=> $stable(so));

    p_take_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take);

endmodule

// File: rtl/spi_mode_frontend.sv
// Module: spi_mode_frontend (top)
// SPI slave serial front end with automatic mode 0 / mode 3 detection.
// Assumes: pins are asynchronous to clk; each serial clock level lasts at
// least three clk cycles; the decoder accepts strobes without backpressure.
module spi_mode_frontend #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic              mode3,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_take
);
    import spi_mfe_pkg::*;

    logic [2:0] s_pins;
    spi_evt_t   evt;
    logic       active;
    spi_mode_e  mode;

    spi_mfe_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST_VAL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cs_n, sck, si}),
        .q_out (s_pins)
    );

    spi_mfe_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_cs   (s_pins[2]),
        .s_sck  (s_pins[1]),
        .evt    (evt),
        .active (active),
        .mode   (mode)
    );

    spi_mfe_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (s_pins[2]),
        .sck_rise (evt.sck_rise),
        .si       (s_pins[0]),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    spi_mfe_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (s_pins[2]),
        .cs_fall   (evt.cs_fall),
        .sck_rise  (evt.sck_rise),
        .sck_fall  (evt.sck_fall),
        .byte_done (rx_valid),
        .tx_data   (tx_data),
        .so        (so),
        .tx_take   (tx_take)
    );

    // Output enable follows the open transaction; mode exported as a bit.
    assign so_oe = active;
    assign mode3 = (mode == MODE_3);

    p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_pins[2] |=> !so_oe);

    p_take_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt.cs_fall |=> tx_take);

endmodule

// File: tb/spi_mode_frontend_test.sv
module spi_mode_frontend_test;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       so, so_oe, mode3, rx_valid, tx_take;
    logic [7:0] rx_data;
    logic [7:0] tx_data = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int         rx_n = 0;
    int         take_n = 0;
    int         tx_idx = 0;
    logic [7:0] rx_q [8];
    logic [7:0] mo_b [4];
    logic [7:0] tx_b [8];

    spi_mode_frontend uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .mode3(mode3),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_take(tx_take)
    );

    always #10 clk = ~clk;

    // Record strobes away from the active edge; feed next transmit byte.
    always @(negedge clk) begin
        if (rx_valid) begin
            if (rx_n < 8) rx_q[rx_n] = rx_data;
            rx_n = rx_n + 1;
        end
        if (tx_take) begin
            take_n = take_n + 1;
            tx_idx = tx_idx + 1;
            tx_data = tx_b[tx_idx & 7];
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_takes(input bit m3, input int nb);
        return m3 ? nb : nb + 1;
    endfunction

    task automatic prep(input int nb);
        for (int b = 0; b < 4; b++) mo_b[b] = 8'($urandom);
        for (int b = 0; b < 8; b++) tx_b[b] = 8'($urandom);
        rx_n = 0; take_n = 0; tx_idx = 0; tx_data = tx_b[0];
        if (nb > 4) $display("bad byte count");
    endtask

    task automatic run_xfer(input bit m3, input int nb);
        prep(nb);
        sck = m3; wait_clk(HALF);
        cs_n = 1'b0; wait_clk(HALF);
        chk("R2", "mode latched", int'(mode3), int'(m3));
        chk("R3", "oe in transaction", int'(so_oe), 1);
        for (int b = 0; b < nb; b++) begin
            for (int i = 7; i >= 0; i--) begin
                sck = 1'b0; si = mo_b[b][i]; wait_clk(HALF);
                chk("R8", "so bit", int'(so), int'(tx_b[b][i]));
                sck = 1'b1; wait_clk(HALF);
            end
        end
        if (!m3) begin sck = 1'b0; wait_clk(HALF); end
        cs_n = 1'b1; wait_clk(HALF);
        chk("R3", "oe released", int'(so_oe), 0);
        chk("R6", "byte strobes", rx_n, nb);
        for (int b = 0; b < nb; b++) chk("R6", "rx byte", int'(rx_q[b]), int'(mo_b[b]));
        chk("R9", "take strobes", take_n, exp_takes(m3, nb));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 8; b++) tx_b[b] = 8'h00;

        // R1: reset state
        wait_clk(6);
        chk("R1", "oe during reset", int'(so_oe), 0);
        rst_n = 1'b1; wait_clk(HALF);
        chk("R1", "mode after reset", int'(mode3), 1);
        chk("R1", "oe after reset", int'(so_oe), 0);
        chk("R1", "no strobe", rx_n, 0);

        // R2/R6/R8/R9: directed transfers in both modes
        run_xfer(1'b0, 1);
        run_xfer(1'b1, 2);
        run_xfer(1'b0, 3);

        // R7: abort mid-byte then a clean byte
        prep(1);
        sck = 1'b0; wait_clk(HALF); cs_n = 1'b0; wait_clk(HALF);
        for (int i = 0; i < 5; i++) begin
            sck = 1'b0; si = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
        end
        sck = 1'b0; wait_clk(HALF); cs_n = 1'b1; wait_clk(HALF);
        chk("R7", "abort no strobe", rx_n, 0);
        chk("R7", "abort oe off", int'(so_oe), 0);
        run_xfer(1'b0, 1);

        // R10: eighth rising edge coincides with select rising
        prep(1);
        sck = 1'b1; wait_clk(HALF); cs_n = 1'b0; wait_clk(HALF);
        for (int i = 0; i < 7; i++) begin
            sck = 1'b0; si = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
        end
        sck = 1'b0; wait_clk(HALF);
        sck = 1'b1; cs_n = 1'b1; wait_clk(2 * HALF);
        chk("R10", "coincident no strobe", rx_n, 0);
        chk("R10", "coincident oe off", int'(so_oe), 0);
        run_xfer(1'b1, 1);

        // R4: select held low through reset release
        prep(1);
        rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; wait_clk(6);
        rst_n = 1'b1; wait_clk(HALF);
        for (int i = 0; i < 8; i++) begin
            sck = 1'b1; si = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
        end
        chk("R4", "no strobe", rx_n, 0);
        chk("R4", "oe off", int'(so_oe), 0);
        chk("R4", "mode unchanged", int'(mode3), 1);
        cs_n = 1'b1; wait_clk(HALF);
        run_xfer(1'b0, 1);

        // R5: reset asserted mid-transaction ignores bits
        prep(1);
        sck = 1'b0; wait_clk(HALF); cs_n = 1'b0; wait_clk(HALF);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; si = 1'b0; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
        end
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sck = 1'b0; si = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
        end
        chk("R5", "no strobe in reset", rx_n, 0);
        chk("R5", "oe off in reset", int'(so_oe), 0);
        cs_n = 1'b1; wait_clk(HALF);
        rst_n = 1'b1; wait_clk(HALF);
        chk("R1", "mode after reset", int'(mode3), 1);
        run_xfer(1'b1, 2);

        // Constrained random transactions
        for (int t = 0; t < 30; t++) begin
            run_xfer(1'($urandom), 1 + int'($urandom % 3));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule